// File: doc/BRIEF.md
# DMA Channel Block Length Counter

This block holds the byte count and start logic of one DMA channel. Software programs a 16-bit block length through two byte-wide register locations. A high-byte write completes the value. That value is also kept as a reload copy.

The channel watches one trigger line. Configuration inputs pick the line by a group index and an offset within that group. A rising edge on the chosen line, seen while the channel is idle, starts a block. The channel's data path then reports each byte it reads on `byte_rd`. Each report lowers the count by one. On the last byte, the count is restored from the reload copy, a one-cycle `done` pulse is produced, and the channel goes idle again.

A stored length of zero at start means a block of 65535 bytes. Each group has a kind, and the kind limits which offsets hold a live trigger. Timer groups have up to six trigger sources. Serial groups have two.

Top module: `dma_blk_counter`

## Requirements
- R1: After reset the count is 0x0001, the reload copy is 0x0001, `busy` and `done` are low, and a read of address 0 returns 0x01.
- R2: A write to address 0 (low byte) only stages the byte and leaves the count unchanged. A later write to address 1 (high byte) loads both the count and the reload copy with {high, staged low}.
- R3: A read strobe at address 0 returns count[7:0] and captures count[15:8]. Address 1 then returns that captured byte, even after the count has moved on.
- R4: The selected line is `trig_lines[trg_grp*6 + trg_off]`. A start needs a rising edge on that line. An edge on any other line has no effect.
- R5: Group g has a kind in bits [2g+1:2g] of GRP_KIND. The valid offsets are 0..5 for kind 0 (first timer), 0..3 for kind 1 (other timer) and 0..1 for kind 2 (serial). Kind 3 has no valid offsets. An offset outside the valid range never starts a block.
- R6: A selected edge starts a block only while `busy` is low. An edge during a block changes neither the count nor the block length.
- R7: Each cycle with `byte_rd` high during a block lowers the count by one. `byte_rd` while idle leaves the count unchanged.
- R8: A `byte_rd` with the count at 1 reloads the count from the reload copy, pulses `done` for exactly one cycle and clears `busy`, all in the same cycle.
- R9: A start with the count at 0 sets the count to 0xFFFF, so the block ends after 65535 byte reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (address 0 captures the high byte) |
| reg_addr | input | 1 | 0 = low byte, 1 = high byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data: count low byte, or captured high byte |
| trg_grp | input | 2 | Trigger group index |
| trg_off | input | 3 | Trigger offset within the group |
| trig_lines | input | 24 | Peripheral event lines, 6 per group |
| byte_rd | input | 1 | One byte read by the channel this cycle |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
Properties check on every cycle that:
- `busy` only rises after a selected edge, and never for an invalid offset;
- the count holds steady while idle;
- each byte read inside a block takes off exactly one;
- the final byte restores the reload copy together with a lone `done` pulse.

Only the bench scenarios can show the rest:
- the staged two-step write and the coherent split read;
- the effect of every line against every group and offset selection;
- the full 65535-byte block that follows a zero length.

// File: rtl/dma_blk_counter.sv
module dma_blk_counter #(
  parameter int REG_W     = 8,
  parameter int NUM_GRP   = 4,
  parameter int GRP_LINES = 6,
  parameter logic [2*NUM_GRP-1:0] GRP_KIND = 8'b10_10_01_00
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic                         reg_addr,
  input  logic [REG_W-1:0]             reg_wdata,
  output logic [REG_W-1:0]             reg_rdata,
  input  logic [$clog2(NUM_GRP)-1:0]   trg_grp,
  input  logic [$clog2(GRP_LINES+2)-1:0] trg_off,
  input  logic [NUM_GRP*GRP_LINES-1:0] trig_lines,
  input  logic                         byte_rd,
  output logic                         busy,
  output logic                         done
);
  localparam int CNT_W = 2 * REG_W;
  localparam int GW    = $clog2(NUM_GRP);
  localparam int OW    = $clog2(GRP_LINES + 2);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, reload;
  logic [REG_W-1:0] lo_stage, rd_hold;
  logic             trig_prev, sel_line, sel_ok, trig_edge, start, last_byte, wr_hi;
  logic [1:0]       kind;
  int               lim;

  always_comb begin
    kind = GRP_KIND[2*trg_grp +: 2];
    case (kind)
      2'd0:    lim = GRP_LINES;
      2'd1:    lim = GRP_LINES - 2;
      2'd2:    lim = 2;
      default: lim = 0;
    endcase
    sel_ok   = int'(trg_off) < lim;
    sel_line = sel_ok ? trig_lines[int'(trg_grp) * GRP_LINES + int'(trg_off)] : 1'b0;
  end

  assign trig_edge = sel_line & ~trig_prev;
  assign start     = trig_edge & ~busy;
  assign last_byte = busy & byte_rd & (cnt == ONE);
  assign wr_hi     = reg_wr & reg_addr;
  assign reg_rdata = reg_addr ? rd_hold : cnt[REG_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= ONE;
      reload    <= ONE;
      lo_stage  <= '0;
      rd_hold   <= '0;
      trig_prev <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      trig_prev <= sel_line;
      done      <= last_byte;
      if (reg_wr && !reg_addr) lo_stage <= reg_wdata;
      if (reg_rd && !reg_addr) rd_hold <= cnt[CNT_W-1:REG_W];
      if (wr_hi) reload <= {reg_wdata, lo_stage};

      if (wr_hi)                    cnt <= {reg_wdata, lo_stage};
      else if (start && cnt == '0)  cnt <= '1;
      else if (last_byte)           cnt <= reload;
      else if (busy && byte_rd)     cnt <= cnt - ONE;

      if (start)          busy <= 1'b1;
      else if (last_byte) busy <= 1'b0;
    end
  end

  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig_edge));
  // R5
  bad_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && !busy) |=> !busy);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_hi && !trig_edge) |=> cnt == $past(cnt));
  // R7
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_rd && cnt > ONE && !wr_hi) |=> cnt == $past(cnt) - ONE);
  // R8
  end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_rd && cnt == ONE && !wr_hi) |=> (done && !busy && cnt == $past(reload)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !byte_rd && !wr_hi) |=> (busy && cnt == $past(cnt)));
endmodule

// File: tb/dma_blk_counter_bench.sv
module dma_blk_counter_bench;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [7:0]  reg_wdata = 0, reg_rdata;
  logic [1:0]  trg_grp = 0;
  logic [2:0]  trg_off = 0;
  logic [23:0] trig_lines = 0;
  logic        byte_rd = 0, busy, done;
  int checks = 0, fails = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  dma_blk_counter u_dma_blk_counter (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_lo(output logic [7:0] d);
    @(negedge clk); reg_addr = 0; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rd_hi(output logic [7:0] d);
    @(negedge clk); reg_addr = 1; #1 d = reg_rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); trig_lines[idx] = 1;
    @(negedge clk); trig_lines[idx] = 0;
  endtask

  task automatic bytes(input int n);
    @(negedge clk); byte_rd = 1;
    repeat (n) @(negedge clk);
    byte_rd = 0;
  endtask

  function automatic int lim_of(input int g);
    int k = (8'b10_10_01_00 >> (2*g)) & 3;
    return k == 0 ? 6 : k == 1 ? 4 : k == 2 ? 2 : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    rd_lo(v); chk("R1 low", v, 8'h01);
    rd_hi(v); chk("R1 high", v, 8'h00);
    // R2 staged write
    wr_byte(0, 8'hAB);
    rd_lo(v); chk("R2 low unchanged", v, 8'h01);
    wr_byte(1, 8'hCD);
    rd_lo(v); chk("R2 low", v, 8'hAB);
    rd_hi(v); chk("R2 high", v, 8'hCD);
    // R7 byte_rd while idle ignored
    bytes(5);
    rd_lo(v); chk("R7 idle low", v, 8'hAB);
    rd_hi(v); chk("R7 idle high", v, 8'hCD);
    // R3 coherent read, R8 reload
    trg_grp = 0; trg_off = 2;
    wr_byte(0, 8'h34); wr_byte(1, 8'h12);
    rd_lo(v); chk("R3 low", v, 8'h34);
    pulse(2);
    chk("R4 start", busy, 1);
    bytes(8'h35);
    rd_hi(v); chk("R3 held high", v, 8'h12);
    rd_lo(v); chk("R7 low after step", v, 8'hFF);
    rd_hi(v); chk("R3 new high", v, 8'h11);
    bytes(16'h11FE);
    chk("R8 not done early", done, 0);
    chk("R8 busy before last", busy, 1);
    bytes(1);
    chk("R8 done", done, 1);
    chk("R8 idle", busy, 0);
    @(negedge clk); chk("R8 one cycle", done, 0);
    rd_lo(v); chk("R8 reload low", v, 8'h34);
    rd_hi(v); chk("R8 reload high", v, 8'h12);
    // R6 trigger during block ignored
    wr_byte(0, 8'd10); wr_byte(1, 8'd0);
    pulse(2); bytes(3);
    pulse(2);
    chk("R6 still busy", busy, 1);
    rd_lo(v); chk("R6 count kept", v, 8'd7);
    bytes(6); chk("R6 no early done", busy, 1);
    bytes(1); chk("R6 done", done, 1);
    // R4 R5 sweep of every selection against every line
    wr_byte(0, 8'd2); wr_byte(1, 8'd0);
    for (int g = 0; g < 4; g++) begin
      for (int o = 0; o < 8; o++) begin
        @(negedge clk); trg_grp = 2'(g); trg_off = 3'(o);
        @(negedge clk);
        for (int j = 0; j < 24; j++) begin
          pulse(j);
          chk($sformatf("R4 R5 g%0d o%0d line%0d", g, o, j), busy,
              (o < lim_of(g) && j == g*6 + o) ? 1 : 0);
          if (busy) begin
            bytes(2);
            chk("R5 block end", done, 1);
          end
        end
      end
    end
    // R9 zero length
    trg_grp = 1; trg_off = 0;
    wr_byte(0, 8'h00); wr_byte(1, 8'h00);
    pulse(6);
    chk("R9 start", busy, 1);
    rd_lo(v); chk("R9 full low", v, 8'hFF);
    rd_hi(v); chk("R9 full high", v, 8'hFF);
    bytes(65534);
    chk("R9 still busy", busy, 1);
    rd_lo(v); chk("R9 last low", v, 8'h01);
    bytes(1);
    chk("R9 done", done, 1);
    rd_lo(v); chk("R9 reload zero", v, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule